// File: doc/BRIEF.md
# Cyclic Audio Buffer Descriptor Generator

This block turns a description of a cyclic audio DMA buffer into the list of descriptor entries that a DMA engine walks through. The buffer is contiguous and is cut into equal periods. A configuration is latched on a start pulse: the base address, the total buffer size, the period size, a position-adjust byte count, a flag that turns off per-period interrupts, and a mode that keeps every chunk inside one 4 KiB page. The block then hands out one entry per accepted beat on a valid/ready port. Each beat carries the four 32-bit words of one descriptor.

A fragment is one period, or the optional leading adjustment region. It becomes one or more entries. Only the entry that finishes a fragment may ask for a completion interrupt. When generation ends, the block shows the number of entries written, the index of the last valid entry, and an error flag. The error flag is raised when the list would grow past its entry limit.

Top module: `bdl_gen`

## Requirements
- R1: Each beat carries four words. The address low and address high words hold the lower and upper 32 bits of base plus the running byte offset, starting at offset 0. The length word holds the chunk size in bytes. The flags word has the interrupt request in bit 0, and bits 31:1 are zero.
- R2: When align_4k is set, a chunk is clipped to 4096 minus the low 12 bits of its offset, so no chunk crosses a 4 KiB offset boundary. When align_4k is clear, each fragment is exactly one entry.
- R3: Bit 0 of the flags word is 1 only on the entry that completes a fragment, and only if that fragment requests an interrupt. Every other entry carries 0.
- R4: The number of periods is the buffer size divided by the period size, rounded down, and leftover bytes are not described. A period size of 0 produces no entries and no error.
- R5: When the adjustment is non-zero and smaller than the period size, it is emitted first as a fragment of that many bytes that requests an interrupt.
- R6: While the adjustment is active, the final period is shortened by the adjustment, so the total described is periods times period size, and it requests no interrupt.
- R7: When no_period_irq is set, regular periods request no interrupt. A leading adjustment fragment still requests one.
- R8: An adjustment greater than or equal to the period size is dropped. No leading fragment is produced and no period is shortened.
- R9: If another entry is needed after MAX_ENTRIES entries have been written, error is set and no further entry is offered. entry_count then reads MAX_ENTRIES.
- R10: After generation, entry_count is the number of accepted entries and last_index is entry_count minus one, modulo 2^CNT_W.
- R11: An offered entry stays valid with unchanged words until it is accepted. A start pulse while busy is ignored.
- R12: After reset, busy, ent_valid, error and entry_count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch the configuration and begin generation (only while idle) |
| base_addr | input | 64 | Buffer base address |
| buf_bytes | input | 32 | Total buffer size in bytes |
| period_bytes | input | 32 | Period size in bytes |
| adj_bytes | input | 32 | Position-adjust byte count |
| no_period_irq | input | 1 | Suppress interrupts on regular periods |
| align_4k | input | 1 | Clip chunks at 4 KiB offset boundaries |
| ent_valid | output | 1 | An entry is offered |
| ent_ready | input | 1 | Consumer accepts the offered entry |
| ent_addr_lo | output | 32 | Entry word 0: address bits 31:0 |
| ent_addr_hi | output | 32 | Entry word 1: address bits 63:32 |
| ent_len | output | 32 | Entry word 2: chunk length in bytes |
| ent_flags | output | 32 | Entry word 3: bit 0 interrupt request |
| busy | output | 1 | Generation in progress |
| error | output | 1 | Entry limit exceeded in the last run |
| entry_count | output | CNT_W | Entries accepted in the current or last run |
| last_index | output | CNT_W | entry_count minus one |

## Verification
The sweep covers three period sizes: below a page, exactly one page, and more than one page. Each is run with one to three periods, with and without leftover bytes, with the adjustment zero, small, or equal to the period, and with every combination of the interrupt and alignment flags. The small-adjustment cases show both the leading fragment and the shortened final period. The page-sized and larger periods show where alignment splits a fragment and which piece carries the interrupt. Directed cases cover a zero period, a list that exactly fills the limit versus one that overflows it, an adjustment above the period, a base with a non-zero upper word, and a start pulse issued in mid-run together with changed inputs. The consumer stalls on a repeating pattern, so held entries are exercised in every run.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 64;
    localparam int IRQ_BIT = 0;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PLAN,
        ST_EMIT
    } gen_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        word_t             period;
        word_t             adj;
        logic              no_irq;
        logic              align;
    } bdl_cfg_t;

    typedef struct packed {
        logic  valid;
        word_t len;
        logic  irq;
    } frag_t;

    function automatic word_t flags_word(input logic irq);
        word_t w;
        w = '0;
        w[IRQ_BIT] = irq;
        return w;
    endfunction

endpackage

// File: rtl/bdl_frag_plan.sv
module bdl_frag_plan
    import bdl_pkg::*;
(
    input  word_t rem_bytes,
    input  word_t period,
    input  word_t adj,
    input  logic  adj_active,
    input  logic  no_irq,
    output frag_t frag,
    output word_t rem_next
);
    logic  fits;
    logic  is_last;
    logic  shorten;

    always_comb begin
        fits     = (period != '0) && (rem_bytes >= period);
        rem_next = rem_bytes - period;
        is_last  = rem_next < period;
        shorten  = is_last && adj_active;
        frag.valid = fits;
        frag.len   = shorten ? (period - adj) : period;
        frag.irq   = shorten ? 1'b0 : ~no_irq;
    end
endmodule

// File: rtl/bdl_chunk_calc.sv
module bdl_chunk_calc
    import bdl_pkg::*;
#(
    parameter int PAGE_BYTES = 4096,
    localparam int PAGE_BITS = $clog2(PAGE_BYTES)
) (
    input  word_t ofs,
    input  word_t left,
    input  logic  align,
    output word_t chunk,
    output logic  frag_end
);
    word_t page_room;

    always_comb begin
        page_room = word_t'(PAGE_BYTES) - word_t'(ofs[PAGE_BITS-1:0]);
        chunk     = (align && (left > page_room)) ? page_room : left;
        frag_end  = (chunk == left);
    end
endmodule

// File: rtl/bdl_gen.sv
module bdl_gen
    import bdl_pkg::*;
#(
    parameter int MAX_ENTRIES = 256,
    parameter int PAGE_BYTES  = 4096,
    localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [63:0]       base_addr,
    input  logic [31:0]       buf_bytes,
    input  logic [31:0]       period_bytes,
    input  logic [31:0]       adj_bytes,
    input  logic              no_period_irq,
    input  logic              align_4k,
    output logic              ent_valid,
    input  logic              ent_ready,
    output logic [31:0]       ent_addr_lo,
    output logic [31:0]       ent_addr_hi,
    output logic [31:0]       ent_len,
    output logic [31:0]       ent_flags,
    output logic              busy,
    output logic              error,
    output logic [CNT_W-1:0]  entry_count,
    output logic [CNT_W-1:0]  last_index
);
    localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_ENTRIES);

    gen_state_e        state_q;
    bdl_cfg_t          cfg_q;
    logic              adj_act_q;
    word_t             rem_q;
    word_t             ofs_q;
    word_t             left_q;
    logic              irq_q;
    logic [CNT_W-1:0]  count_q;
    logic              err_q;

    frag_t             nxt_frag;
    word_t             rem_after;
    word_t             chunk;
    logic              frag_end;
    logic              at_cap;
    logic              adj_ok;
    logic [ADDR_W-1:0] cur_addr;

    bdl_frag_plan u_plan (
        .rem_bytes  (rem_q),
        .period     (cfg_q.period),
        .adj        (cfg_q.adj),
        .adj_active (adj_act_q),
        .no_irq     (cfg_q.no_irq),
        .frag       (nxt_frag),
        .rem_next   (rem_after)
    );

    bdl_chunk_calc #(.PAGE_BYTES(PAGE_BYTES)) u_chunk (
        .ofs      (ofs_q),
        .left     (left_q),
        .align    (cfg_q.align),
        .chunk    (chunk),
        .frag_end (frag_end)
    );

    assign adj_ok   = (adj_bytes != '0) && (adj_bytes < period_bytes);
    assign at_cap   = (count_q == CNT_CAP);
    assign cur_addr = cfg_q.base + {{(ADDR_W-WORD_W){1'b0}}, ofs_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cfg_q     <= '0;
            adj_act_q <= 1'b0;
            rem_q     <= '0;
            ofs_q     <= '0;
            left_q    <= '0;
            irq_q     <= 1'b0;
            count_q   <= '0;
            err_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q.base   <= base_addr;
                        cfg_q.period <= period_bytes;
                        cfg_q.adj    <= adj_bytes;
                        cfg_q.no_irq <= no_period_irq;
                        cfg_q.align  <= align_4k;
                        adj_act_q    <= adj_ok;
                        rem_q        <= buf_bytes;
                        ofs_q        <= '0;
                        count_q      <= '0;
                        err_q        <= 1'b0;
                        left_q       <= adj_bytes;
                        irq_q        <= 1'b1;
                        state_q      <= adj_ok ? ST_EMIT : ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    if (nxt_frag.valid) begin
                        rem_q   <= rem_after;
                        left_q  <= nxt_frag.len;
                        irq_q   <= nxt_frag.irq;
                        state_q <= ST_EMIT;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_EMIT: begin
                    if (at_cap) begin
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (ent_ready) begin
                        count_q <= count_q + CNT_W'(1);
                        ofs_q   <= ofs_q + chunk;
                        left_q  <= left_q - chunk;
                        if (frag_end) state_q <= ST_PLAN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ent_valid   = (state_q == ST_EMIT) && !at_cap;
    assign ent_addr_lo = cur_addr[WORD_W-1:0];
    assign ent_addr_hi = cur_addr[ADDR_W-1:WORD_W];
    assign ent_len     = chunk;
    assign ent_flags   = flags_word(irq_q && frag_end);
    assign busy        = (state_q != ST_IDLE);
    assign error       = err_q;
    assign entry_count = count_q;
    assign last_index  = count_q - CNT_W'(1);

endmodule

// File: rtl/bdl_gen_chk.sv
module bdl_gen_chk #(
    parameter int MAX_ENTRIES = 256,
    parameter int PAGE_BYTES  = 4096,
    parameter int CNT_W       = 9,
    localparam int PAGE_BITS  = $clog2(PAGE_BYTES)
) (
    input logic             clk,
    input logic             rst,
    input logic             ent_valid,
    input logic             ent_ready,
    input logic [31:0]      ent_addr_lo,
    input logic [31:0]      ent_addr_hi,
    input logic [31:0]      ent_len,
    input logic [31:0]      ent_flags,
    input logic             busy,
    input logic [CNT_W-1:0] entry_count,
    input logic             align_q,
    input logic [31:0]      ofs_q
);
    AST_FLAGS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        ent_valid |-> (ent_flags[31:1] == '0)); // R1

    AST_NONZERO_LEN: assert property (@(posedge clk) disable iff (rst)
        ent_valid |-> (ent_len != '0)); // R2

    AST_PAGE_FIT: assert property (@(posedge clk) disable iff (rst)
        (ent_valid && align_q) |->
        ((33'(ofs_q[PAGE_BITS-1:0]) + 33'(ent_len)) <= 33'(PAGE_BYTES))); // R2

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
        entry_count <= CNT_W'(MAX_ENTRIES)); // R9

    AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (ent_valid && !ent_ready) |=> (ent_valid && $stable(ent_addr_lo) &&
        $stable(ent_addr_hi) && $stable(ent_len) && $stable(ent_flags))); // R11

    AST_VALID_BUSY: assert property (@(posedge clk) disable iff (rst)
        ent_valid |-> busy); // R11
endmodule

bind bdl_gen bdl_gen_chk #(
    .MAX_ENTRIES (MAX_ENTRIES),
    .PAGE_BYTES  (PAGE_BYTES),
    .CNT_W       (CNT_W)
) u_bdl_gen_chk (
    .clk         (clk),
    .rst         (rst),
    .ent_valid   (ent_valid),
    .ent_ready   (ent_ready),
    .ent_addr_lo (ent_addr_lo),
    .ent_addr_hi (ent_addr_hi),
    .ent_len     (ent_len),
    .ent_flags   (ent_flags),
    .busy        (busy),
    .entry_count (entry_count),
    .align_q     (cfg_q.align),
    .ofs_q       (ofs_q)
);

// File: tb/test_bdl_gen.sv
module test_bdl_gen;
    localparam int MAXE  = 16;
    localparam int CW    = $clog2(MAXE + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [63:0]   base_addr = '0;
    logic [31:0]   buf_bytes = '0;
    logic [31:0]   period_bytes = '0;
    logic [31:0]   adj_bytes = '0;
    logic          no_period_irq = 1'b0;
    logic          align_4k = 1'b0;
    logic          ent_valid;
    logic          ent_ready = 1'b0;
    logic [31:0]   ent_addr_lo, ent_addr_hi, ent_len, ent_flags;
    logic          busy, error;
    logic [CW-1:0] entry_count, last_index;

    bdl_gen #(.MAX_ENTRIES(MAXE), .PAGE_BYTES(4096)) i_bdl_gen (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .buf_bytes(buf_bytes), .period_bytes(period_bytes), .adj_bytes(adj_bytes),
        .no_period_irq(no_period_irq), .align_4k(align_4k),
        .ent_valid(ent_valid), .ent_ready(ent_ready),
        .ent_addr_lo(ent_addr_lo), .ent_addr_hi(ent_addr_hi),
        .ent_len(ent_len), .ent_flags(ent_flags),
        .busy(busy), .error(error),
        .entry_count(entry_count), .last_index(last_index)
    );

    always #5 clk = ~clk;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    logic [63:0] m_addr [64];
    logic [31:0] m_len  [64];
    bit          m_irq  [64];
    int          m_n;
    bit          m_err;
    logic [31:0] m_ofs;
    bit          m_align;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic add_frag(input logic [31:0] len, input bit irq, input logic [63:0] base);
        logic [31:0] left;
        logic [31:0] c;
        logic [31:0] room;
        left = len;
        while (left > 0 && !m_err) begin
            if (m_n >= MAXE) begin
                m_err = 1'b1;
            end else begin
                room = 32'h1000 - (m_ofs & 32'hFFF);
                c = (m_align && left > room) ? room : left;
                m_addr[m_n] = base + 64'(m_ofs);
                m_len[m_n]  = c;
                left        = left - c;
                m_irq[m_n]  = (left == 0) && irq;
                m_n++;
                m_ofs = m_ofs + c;
            end
        end
    endtask

    task automatic build_model(input logic [63:0] base, input logic [31:0] bufb,
                               input logic [31:0] per, input logic [31:0] adj,
                               input bit noirq, input bit al);
        bit act;
        int np;
        m_n = 0; m_err = 1'b0; m_ofs = '0; m_align = al;
        act = (adj != 0) && (adj < per);
        np  = (per == 0) ? 0 : int'(bufb / per);
        if (act) add_frag(adj, 1'b1, base);
        for (int i = 0; i < np; i++) begin
            if (i == np - 1 && act) add_frag(per - adj, 1'b0, base);
            else                    add_frag(per, !noirq, base);
        end
    endtask

    task automatic run_case(input string tag, input logic [63:0] base,
                            input logic [31:0] bufb, input logic [31:0] per,
                            input logic [31:0] adj, input bit noirq, input bit al,
                            input bit poke);
        int got;
        int cyc;
        build_model(base, bufb, per, adj, noirq, al);
        @(negedge clk);
        base_addr = base; buf_bytes = bufb; period_bytes = per; adj_bytes = adj;
        no_period_irq = noirq; align_4k = al; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 0; cyc = 0;
        forever begin
            ent_ready = ((cyc % 3) != 1);
            if (poke && cyc == 3) begin
                start = 1'b1; buf_bytes = 32'h40; period_bytes = 32'h10;
            end
            if (poke && cyc == 4) begin
                start = 1'b0; buf_bytes = bufb; period_bytes = per;
            end
            #1;
            if (ent_valid && ent_ready) begin
                if (got < m_n) begin
                    chk({ent_addr_hi, ent_addr_lo} == m_addr[got], "R1", "entry address",
                        {ent_addr_hi, ent_addr_lo}, m_addr[got]);
                    chk(ent_len == m_len[got], "R2", "entry length", 64'(ent_len), 64'(m_len[got]));
                    chk(ent_flags == 32'(m_irq[got]), "R3", "entry flags",
                        64'(ent_flags), 64'(m_irq[got]));
                end else begin
                    chk(1'b0, "R11", "extra entry offered", 64'(got), 64'(m_n));
                end
                got++;
            end
            if (!busy) break;
            @(negedge clk);
            cyc++;
        end
        chk(got == m_n, tag, "entries accepted", 64'(got), 64'(m_n));
        chk(entry_count == CW'(m_n), "R10", "entry_count", 64'(entry_count), 64'(m_n));
        chk(last_index == CW'(m_n - 1), "R10", "last_index", 64'(last_index), 64'(CW'(m_n - 1)));
        chk(error == m_err, "R9", "error flag", 64'(error), 64'(m_err));
        ent_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] pers [3];
        logic [31:0] adj, bufb;
        string tag;
        pers[0] = 32'h600; pers[1] = 32'h1000; pers[2] = 32'h1C00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!busy && !ent_valid && !error && entry_count == '0, "R12", "reset state",
            {60'b0, busy, ent_valid, error, |entry_count}, 64'h0);

        for (int p = 0; p < 3; p++)
            for (int np = 1; np <= 3; np++)
                for (int a = 0; a < 3; a++)
                    for (int ni = 0; ni < 2; ni++)
                        for (int al = 0; al < 2; al++) begin
                            adj  = (a == 0) ? 32'h0 : (a == 1) ? 32'h80 : pers[p];
                            bufb = pers[p] * np + ((a == 1) ? 32'h40 : 32'h0);
                            if (a == 1)       tag = "R6";
                            else if (a == 2)  tag = "R8";
                            else if (ni == 1) tag = "R7";
                            else              tag = "R4";
                            run_case(tag, 64'h0000_0000_0000_0F00 + 64'(p * 32'h340),
                                     bufb, pers[p], adj, ni[0], al[0], 1'b0);
                        end

        run_case("R5", 64'h0000_0001_0000_0800, 32'h3000, 32'h1000, 32'h200, 1'b1, 1'b1, 1'b0);
        run_case("R7", 64'h0000_0000_2000_0000, 32'h2400, 32'h900, 32'h0, 1'b1, 1'b0, 1'b0);
        run_case("R4", 64'h0000_0000_0000_4000, 32'h2000, 32'h0, 32'h100, 1'b0, 1'b1, 1'b0);
        run_case("R8", 64'h0000_0000_0000_0000, 32'h1800, 32'h800, 32'h801, 1'b0, 1'b0, 1'b0);
        run_case("R9", 64'h0000_0000_0001_0000, 32'h1400, 32'h100, 32'h0, 1'b0, 1'b0, 1'b0);
        run_case("R10", 64'h0000_0000_0001_0000, 32'h1000, 32'h100, 32'h0, 1'b0, 1'b0, 1'b0);
        run_case("R9", 64'h0000_0000_0000_0000, 32'h1000, 32'h100, 32'h40, 1'b0, 1'b1, 1'b0);
        run_case("R11", 64'h0000_0002_FFFF_F000, 32'h3000, 32'h1000, 32'h0, 1'b0, 1'b1, 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule